// File: doc/BRIEF.md
# Product-Term Cluster Steering Allocator

This block sits between the product-term array of one logic block and its sixteen macrocells. The array delivers 64 product terms as sixteen clusters of four. The allocator sends each cluster to one macrocell of its choice, and each macrocell's logic input is the OR of every cluster sent to it. Several clusters can be pooled onto one macrocell, up to eight of them. A macrocell can therefore compute a sum of up to 32 product terms in a single pass through the array.

Each cluster has a small configuration word. The word names the target macrocell, selects three-term or four-term use, and enables or disables the cluster. A cluster in three-term mode leaves its top term out of the sum. That term goes instead to the receiving macrocell's separate XOR input. Each macrocell can only take clusters from a fixed sliding window of neighbours. A configuration that breaks this rule is dropped from the datapath and latches an error flag. The steering path itself is combinational. Only the configuration words and the error flag are registered.

Top module: `pt_steer_alloc`

## Requirements
- R1: While reset is held, and right after it, every cluster is disabled, all of `mc_sum` and `mc_xor` read 0, and `config_error` is 0.
- R2: A macrocell that no enabled, legal cluster targets drives 0 on both `mc_sum[m]` and `mc_xor[m]`. A disabled cluster (enable bit 0) contributes nothing.
- R3: In four-term mode (mode bit 0), cluster c contributes the OR of `pt_in[4c+3:4c]` to its target's `mc_sum` bit and nothing to `mc_xor`.
- R4: In three-term mode (mode bit 1), cluster c contributes the OR of `pt_in[4c+2:4c]` to its target's `mc_sum` bit. Term `pt_in[4c+3]` is ORed into the target's `mc_xor` bit.
- R5: Clusters aimed at the same macrocell are ORed together. Up to eight clusters, 32 terms in all, can be pooled onto one macrocell.
- R6: Macrocell m accepts cluster c only if c lies in an inclusive window that depends on m.
  - Lower bounds for m = 0..15: 0,0,0,0,0,1,2,3,5,6,7,8,8,9,10,11.
  - Upper bounds for m = 0..15: 4,5,6,7,7,8,9,10,12,13,14,15,15,15,15,15.
  - An enabled cluster whose target is outside this window drives no output.
- R7: `config_error` goes to 1 on the clock edge that stores an enabled, out-of-window configuration. It then stays at 1 until reset. Writing an out-of-window target with enable 0 does not set it.
- R8: A write with `cfg_we`=1 stores `cfg_wdata` into the word of cluster `cfg_addr` on the rising edge. The fields are bits [3:0] target macrocell, bit [4] mode and bit [5] enable. The new routing applies from that edge on and not before it. A rewrite moves the cluster, since each cluster has exactly one target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Cluster index being written |
| cfg_wdata | input | 6 | {enable, three-term mode, target[3:0]} |
| pt_in | input | 64 | Product terms, cluster c at bits 4c+3..4c |
| mc_sum | output | 16 | Per-macrocell sum-of-clusters input |
| mc_xor | output | 16 | Per-macrocell spare term for the XOR gate |
| config_error | output | 1 | Sticky flag for an enabled out-of-window configuration |

## Verification
On every cycle the assertions check four things. The error flag never drops once set. Any enabled out-of-window write raises it on the next edge. All-zero product terms give all-zero outputs. A nonzero XOR output always has some spare term high behind it. They also check that the outputs stay still while neither the terms nor the configuration move. The exact window edges need the directed scenarios, because each cluster must be tried just inside and just outside its window. The same holds for the OR pooling of eight clusters onto one macrocell, the redirection of the fourth term in three-term mode, and the edge at which a rewrite moves a cluster.

// File: rtl/pt_steer_pkg.sv
`timescale 1ns/1ps
package pt_steer_pkg;
  localparam int NUM_CL    = 16;
  localparam int NUM_MC    = 16;
  localparam int PT_PER_CL = 4;
  localparam int TGT_W     = $clog2(NUM_MC);
  localparam int CL_W      = $clog2(NUM_CL);
  localparam int NUM_PT    = NUM_CL * PT_PER_CL;
  localparam int CFG_W     = TGT_W + 2;

  typedef struct packed {
    logic             en;
    logic             three;
    logic [TGT_W-1:0] tgt;
  } cl_cfg_t;

  // Lowest cluster index reachable by macrocell m
  function automatic int win_lo(input int m);
    if (m <= 4)       return 0;
    else if (m <= 7)  return m - 4;
    else if (m <= 11) return m - 3;
    else              return m - 4;
  endfunction

  // Highest cluster index reachable by macrocell m
  function automatic int win_hi(input int m);
    if (m <= 3)       return m + 4;
    else if (m == 4)  return 7;
    else if (m <= 7)  return m + 3;
    else if (m <= 11) return m + 4;
    else              return 15;
  endfunction

  function automatic logic cl_legal(input int c, input int m);
    return (c >= win_lo(m)) && (c <= win_hi(m));
  endfunction
endpackage

// File: rtl/pt_steer_rst_sync.sv
`timescale 1ns/1ps
module pt_steer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pt_steer_cfg_regs.sv
`timescale 1ns/1ps
module pt_steer_cfg_regs
  import pt_steer_pkg::*;
#(
  parameter int NCL  = NUM_CL,
  localparam int AW  = $clog2(NCL)
) (
  input  logic                 clk,
  input  logic                 srst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  cl_cfg_t              wdata,
  output cl_cfg_t [NCL-1:0]    cfg_o,
  output logic                 err_o
);
  cl_cfg_t [NCL-1:0] cfg_q, cfg_d;
  logic              err_q, err_d;
  logic              wr_bad;

  // An enabled word aimed outside its window latches the error
  always_comb begin
    wr_bad = wdata.en && !cl_legal(int'(addr), int'(wdata.tgt));
  end

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (we) begin
      cfg_d[addr] = wdata;
      if (wr_bad) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (we) begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;
endmodule

// File: rtl/pt_steer_legal.sv
`timescale 1ns/1ps
module pt_steer_legal
  import pt_steer_pkg::*;
#(
  parameter int NCL = NUM_CL
) (
  input  cl_cfg_t [NCL-1:0] cfg,
  output logic    [NCL-1:0] route
);
  for (genvar c = 0; c < NCL; c++) begin : g_cl
    assign route[c] = cfg[c].en && cl_legal(c, int'(cfg[c].tgt));
  end
endmodule

// File: rtl/pt_steer_xbar.sv
`timescale 1ns/1ps
module pt_steer_xbar
  import pt_steer_pkg::*;
#(
  parameter int NCL = NUM_CL,
  parameter int NMC = NUM_MC,
  parameter int PPC = PT_PER_CL,
  localparam int NPT = NCL * PPC
) (
  input  cl_cfg_t [NCL-1:0] cfg,
  input  logic    [NCL-1:0] route,
  input  logic    [NPT-1:0] pt,
  output logic    [NMC-1:0] sum_o,
  output logic    [NMC-1:0] xor_o
);
  logic [NCL-1:0] cl_full;
  logic [NCL-1:0] cl_low;
  logic [NCL-1:0] cl_spare;

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    assign cl_full[c]  = |pt[c*PPC +: PPC];
    assign cl_low[c]   = |pt[c*PPC +: PPC-1];
    assign cl_spare[c] = pt[c*PPC + PPC - 1];
  end

  always_comb begin
    sum_o = '0;
    xor_o = '0;
    for (int m = 0; m < NMC; m++) begin
      for (int c = 0; c < NCL; c++) begin
        if (route[c] && (cfg[c].tgt == TGT_W'(m))) begin
          if (cfg[c].three) begin
            sum_o[m] = sum_o[m] | cl_low[c];
            xor_o[m] = xor_o[m] | cl_spare[c];
          end else begin
            sum_o[m] = sum_o[m] | cl_full[c];
          end
        end
      end
    end
  end
endmodule

// File: rtl/pt_steer_alloc.sv
`timescale 1ns/1ps
module pt_steer_alloc
  import pt_steer_pkg::*;
#(
  parameter int NCL = NUM_CL,
  parameter int NMC = NUM_MC,
  parameter int PPC = PT_PER_CL,
  localparam int AW  = $clog2(NCL),
  localparam int NPT = NCL * PPC,
  localparam int DW  = $clog2(NMC) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [NPT-1:0] pt_in,
  output logic [NMC-1:0] mc_sum,
  output logic [NMC-1:0] mc_xor,
  output logic           config_error
);
  logic              rst_sync_n;
  cl_cfg_t [NCL-1:0] cfg;
  logic    [NCL-1:0] route;

  pt_steer_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (rst_sync_n)
  );

  pt_steer_cfg_regs #(.NCL(NCL)) u_cfg (
    .clk    (clk),
    .srst_n (rst_sync_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cl_cfg_t'(cfg_wdata)),
    .cfg_o  (cfg),
    .err_o  (config_error)
  );

  pt_steer_legal #(.NCL(NCL)) u_legal (
    .cfg   (cfg),
    .route (route)
  );

  pt_steer_xbar #(.NCL(NCL), .NMC(NMC), .PPC(PPC)) u_xbar (
    .cfg   (cfg),
    .route (route),
    .pt    (pt_in),
    .sum_o (mc_sum),
    .xor_o (mc_xor)
  );
endmodule

// File: rtl/pt_steer_alloc_chk.sv
`timescale 1ns/1ps
module pt_steer_alloc_chk
  import pt_steer_pkg::*;
#(
  parameter int NCL = NUM_CL,
  parameter int NMC = NUM_MC,
  parameter int PPC = PT_PER_CL,
  localparam int AW  = $clog2(NCL),
  localparam int NPT = NCL * PPC,
  localparam int DW  = $clog2(NMC) + 2
) (
  input logic           clk,
  input logic           srst_n,
  input logic           cfg_we,
  input logic [AW-1:0]  cfg_addr,
  input logic [DW-1:0]  cfg_wdata,
  input logic [NPT-1:0] pt_in,
  input logic [NMC-1:0] mc_sum,
  input logic [NMC-1:0] mc_xor,
  input logic           config_error
);
  function automatic logic [NPT-1:0] spare_mask();
    logic [NPT-1:0] v = '0;
    for (int c = 0; c < NCL; c++) v[c*PPC + PPC - 1] = 1'b1;
    return v;
  endfunction
  localparam logic [NPT-1:0] SPARE = spare_mask();

  logic bad_wr;
  assign bad_wr = cfg_wdata[DW-1] &&
                  !cl_legal(int'(cfg_addr), int'(cfg_wdata[DW-3:0]));

  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    config_error |=> config_error);

  a_r7_bad_write_flags: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_we && bad_wr) |=> config_error);

  a_r2_idle_terms_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (pt_in == '0) |-> ((mc_sum == '0) && (mc_xor == '0)));

  a_r4_xor_from_spare: assert property (@(posedge clk) disable iff (!srst_n)
    (mc_xor != '0) |-> ((pt_in & SPARE) != '0));

  a_r8_no_write_holds: assert property (@(posedge clk) disable iff (!srst_n)
    !cfg_we |=> ($stable(pt_in) |-> ($stable(mc_sum) && $stable(mc_xor))));
endmodule

bind pt_steer_alloc pt_steer_alloc_chk #(.NCL(NCL), .NMC(NMC), .PPC(PPC)) u_chk (
  .clk          (clk),
  .srst_n       (rst_sync_n),
  .cfg_we       (cfg_we),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .pt_in        (pt_in),
  .mc_sum       (mc_sum),
  .mc_xor       (mc_xor),
  .config_error (config_error)
);

// File: tb/pt_steer_alloc_tb_top.sv
`timescale 1ns/1ps
module pt_steer_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [5:0]  cfg_wdata;
  logic [63:0] pt_in;
  logic [15:0] mc_sum, mc_xor;
  logic        config_error;

  int n_run = 0;
  int n_fail = 0;

  // Window bounds from R6
  int lo_b [16] = '{0,0,0,0,0,1,2,3,5,6,7,8,8,9,10,11};
  int hi_b [16] = '{4,5,6,7,7,8,9,10,12,13,14,15,15,15,15,15};

  bit     m_en [16];
  bit     m_th [16];
  int     m_tg [16];
  bit     m_err;

  always #2.5 clk = ~clk;

  pt_steer_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pt_in(pt_in), .mc_sum(mc_sum), .mc_xor(mc_xor),
    .config_error(config_error)
  );

  function automatic bit in_win(int c, int m);
    return c >= lo_b[m] && c <= hi_b[m];
  endfunction

  task automatic expect_out(string req, output logic [15:0] es, output logic [15:0] ex);
    es = '0; ex = '0;
    for (int c = 0; c < 16; c++) begin
      if (m_en[c] && in_win(c, m_tg[c])) begin
        if (m_th[c]) begin
          es[m_tg[c]] |= |pt_in[4*c +: 3];
          ex[m_tg[c]] |= pt_in[4*c+3];
        end else begin
          es[m_tg[c]] |= |pt_in[4*c +: 4];
        end
      end
    end
  endtask

  task automatic check(string req);
    logic [15:0] es, ex;
    #1;
    expect_out(req, es, ex);
    n_run++;
    if (mc_sum !== es || mc_xor !== ex || config_error !== m_err) begin
      n_fail++;
      $display("FAIL %s: sum=%h xor=%h err=%b expected sum=%h xor=%h err=%b",
               req, mc_sum, mc_xor, config_error, es, ex, m_err);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 16; c++) begin
      m_en[c] = 0; m_th[c] = 0; m_tg[c] = 0;
    end
    m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // R8 field layout: [5] enable, [4] three-term mode, [3:0] target
  task automatic wr(int c, bit en, bit th, int tg);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'(c); cfg_wdata = {en, th, 4'(tg)};
    @(negedge clk);
    cfg_we = 0;
    m_en[c] = en; m_th[c] = th; m_tg[c] = tg;
    if (en && !in_win(c, tg)) m_err = 1;
  endtask

  task automatic clear_all();
    for (int c = 0; c < 16; c++) wr(c, 0, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; pt_in = '1;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after reset");
  endtask

  task automatic t_four_term();
    wr(2, 1, 0, 1);
    for (int b = 0; b < 4; b++) begin
      pt_in = 64'(1) << (8 + b);
      check("R3 single term of cluster 2");
    end
    pt_in = 64'hFFFF_FFFF_FFFF_F0FF;
    check("R2 other clusters idle");
    pt_in = '0;
    check("R2 all zero");
  endtask

  task automatic t_three_term();
    wr(2, 1, 1, 1);
    pt_in = 64'h0000_0000_0000_0800;
    check("R4 fourth term to xor");
    pt_in = 64'h0000_0000_0000_0100;
    check("R4 low term to sum");
    wr(3, 1, 1, 1);
    pt_in = 64'h0000_0000_0000_8000;
    check("R4 second spare ORed into xor");
  endtask

  task automatic t_wide();
    clear_all();
    for (int c = 0; c < 8; c++) wr(c, 1, 0, 3);
    for (int b = 0; b < 40; b++) begin
      pt_in = 64'(1) << b;
      check("R5 pooled 32 terms on M3");
    end
  endtask

  task automatic t_disabled();
    clear_all();
    wr(0, 0, 0, 15);
    pt_in = '1;
    check("R7 disabled illegal no error");
    check("R2 disabled contributes nothing");
  endtask

  task automatic t_window();
    clear_all();
    wr(4, 1, 0, 0);
    wr(11, 1, 0, 15);
    wr(7, 1, 0, 4);
    wr(8, 1, 0, 12);
    wr(3, 1, 0, 7);
    pt_in = '1;
    check("R6 window edges accepted");
    wr(5, 1, 0, 0);
    check("R6 C5 to M0 ignored, R7 flag");
    wr(10, 1, 0, 15);
    wr(8, 1, 0, 4);
    check("R6 C10->M15 and C8->M4 ignored");
  endtask

  task automatic t_sticky();
    wr(1, 1, 0, 1);
    wr(1, 0, 0, 0);
    check("R7 error stays set");
    do_reset();
    pt_in = '1;
    check("R7 reset clears error");
  endtask

  task automatic t_move();
    clear_all();
    pt_in = '1;
    wr(9, 1, 0, 6);
    check("R8 C9 on M6");
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'd9; cfg_wdata = {1'b1, 1'b0, 4'd9};
    check("R8 no effect before edge");
    @(negedge clk);
    cfg_we = 0;
    m_tg[9] = 9;
    check("R8 moved to M9");
  endtask

  initial begin
    t_reset();
    t_four_term();
    t_three_term();
    t_wide();
    t_disabled();
    t_window();
    t_sticky();
    t_move();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #500000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule